// File: doc/BRIEF.md
# Lane-Partitioned SIMD Vector ALU

This block performs one vector arithmetic or logic operation on two source vectors of `NUM_ELEM` 32-bit elements each. A width code selected with every operation partitions the vector into lanes of 8, 16, 32 or 64 bits. Carries, borrows and shifted bits stay inside a lane. A 64-bit lane is built from an even element (low half) and the next odd element (high half). The supported operations are bitwise AND, OR and XOR, add, subtract, a one-bit logical shift left or right, and a lane multiply. The multiply takes the low half of each lane and returns the double-width product.

The issuing logic presents both flattened source vectors, an operation code and a width code, and pulses `start` for one cycle. One cycle later the registered result appears with a one-cycle `valid` pulse. An operation and width pair that the block does not support raises `err` together with `valid` and leaves the result register unchanged. The register file, the memory path and instruction decode sit outside this block.

Top module: `vec_simd_alu`

## Requirements
- R1: While reset is held, and until the first `start` after it, `valid` and `err` are 0 and `result` is all zeros.
- R2: `valid` is high for exactly the one cycle after a cycle with `start` high. `result` does not change in any cycle that does not follow a `start`.
- R3: Operation codes 0 (AND), 1 (OR) and 2 (XOR) act bitwise over the whole vector for every width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit lanes).
- R4: Operation code 3 (add) with width code 0, 1 or 2 adds each 8-, 16- or 32-bit lane modulo its own size. No carry crosses into the next lane.
- R5: Operation code 3 with width code 3 adds 64-bit lanes made of element 2i (low) and element 2i+1 (high). The carry out of the low element enters the high element.
- R6: Operation code 4 (subtract, first minus second) wraps each lane on its own for width codes 0 to 2. With width code 3, the borrow of element 2i is taken from element 2i+1.
- R7: Operation code 5 shifts every lane left by one bit. A zero enters at the lane's bit 0 and the lane's top bit is dropped. With width code 3, bit 31 of element 2i moves into bit 0 of element 2i+1.
- R8: Operation code 6 shifts every lane right by one bit. A zero enters at the lane's top bit and bit 0 is dropped. With width code 3, bit 0 of element 2i+1 moves into bit 31 of element 2i.
- R9: Operation code 7 (multiply) with width code 1 writes into each 32-bit element the unsigned product of the two sources' bits 15:0 of that element.
- R10: Operation code 7 with width code 0 writes into each 16-bit half of every element the unsigned product of the low bytes of that half.
- R11: Operation code 7 with width code 2 or 3 is rejected. `err` is high in the `valid` cycle and `result` keeps its previous value. `err` is 0 for every other combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches an operation on the current inputs |
| op_code | input | 3 | Operation select (0 AND, 1 OR, 2 XOR, 3 add, 4 sub, 5 shift left, 6 shift right, 7 multiply) |
| width_code | input | 2 | Lane width select (0 8-bit, 1 16-bit, 2 32-bit, 3 64-bit) |
| src_a | input | NUM_ELEM*32 | First source vector, element 0 in the low bits |
| src_b | input | NUM_ELEM*32 | Second source vector, element 0 in the low bits |
| result | output | NUM_ELEM*32 | Registered result vector |
| valid | output | 1 | One-cycle pulse marking a new result |
| err | output | 1 | Unsupported operation/width pair, valid with `valid` |

## Verification
The bench builds the block with its defaults: `NUM_ELEM` = 8, so four 64-bit lane pairs, and the multiplier variant present. With four pairs, a carry, borrow or shifted bit can be seen to move between the two elements of each pair but never across a pair boundary. Random operands expose the same fact at every 8-bit and 16-bit lane boundary inside each element. Directed all-ones and single-bit operands place the boundary cases exactly at those edges.

// File: rtl/vsa_pkg.sv
package vsa_pkg;

   localparam int unsigned ELEM_BITS = 32;
   localparam int unsigned PAIR_BITS = 2 * ELEM_BITS;

   typedef enum logic [2:0] {
      VOP_AND = 3'd0,
      VOP_OR  = 3'd1,
      VOP_XOR = 3'd2,
      VOP_ADD = 3'd3,
      VOP_SUB = 3'd4,
      VOP_SHL = 3'd5,
      VOP_SHR = 3'd6,
      VOP_MUL = 3'd7
   } vop_e;

   typedef enum logic [1:0] {
      LW_8  = 2'd0,
      LW_16 = 2'd1,
      LW_32 = 2'd2,
      LW_64 = 2'd3
   } lane_w_e;

   // number of bits in one lane for a width code
   function automatic int unsigned lane_bits(input lane_w_e w);
      return 8 << w;
   endfunction

endpackage

// File: rtl/vsa_pair_addsub.sv
module vsa_pair_addsub
   import vsa_pkg::*;
#(
   parameter int unsigned SEG_W = 8
) (
   input  logic [PAIR_BITS-1:0] a,
   input  logic [PAIR_BITS-1:0] b,
   input  lane_w_e              wsel,
   input  logic                 do_sub,
   output logic [PAIR_BITS-1:0] sum
);

   localparam int unsigned NSEG = PAIR_BITS / SEG_W;

   initial begin
      if (PAIR_BITS % SEG_W != 0 || SEG_W > 8)
         $error("vsa_pair_addsub: segment width must divide the pair and be at most 8");
   end

   logic [NSEG:0]         cy;
   logic [PAIR_BITS-1:0]  b_eff;

   // segmented ripple: the carry into a segment that opens a lane is
   // forced to the operation's initial carry (0 add, 1 subtract)
   always_comb begin
      b_eff = do_sub ? ~b : b;
      cy    = '0;
      sum   = '0;
      for (int s = 0; s < NSEG; s++) begin
         logic              opens;
         logic              cin;
         logic [SEG_W:0]    part;
         opens = ((s * SEG_W) % lane_bits(wsel)) == 0;
         cin   = opens ? do_sub : cy[s];
         part  = {1'b0, a[s*SEG_W +: SEG_W]} + {1'b0, b_eff[s*SEG_W +: SEG_W]}
                 + {{SEG_W{1'b0}}, cin};
         sum[s*SEG_W +: SEG_W] = part[SEG_W-1:0];
         cy[s+1]               = part[SEG_W];
      end
   end

endmodule

// File: rtl/vsa_pair_shift.sv
module vsa_pair_shift
   import vsa_pkg::*;
(
   input  logic [PAIR_BITS-1:0] a,
   input  lane_w_e              wsel,
   input  logic                 to_right,
   output logic [PAIR_BITS-1:0] q
);

   always_comb begin
      q = '0;
      for (int i = 0; i < PAIR_BITS; i++) begin
         int unsigned pos;
         pos = i % lane_bits(wsel);
         if (!to_right) begin
            q[i] = (pos == 0) ? 1'b0 : a[(i + PAIR_BITS - 1) % PAIR_BITS];
         end else begin
            q[i] = (pos == lane_bits(wsel) - 1) ? 1'b0 : a[(i + 1) % PAIR_BITS];
         end
      end
   end

endmodule

// File: rtl/vsa_elem_mul.sv
module vsa_elem_mul
   import vsa_pkg::*;
(
   input  logic [ELEM_BITS-1:0] a,
   input  logic [ELEM_BITS-1:0] b,
   input  logic                 byte_mode,
   output logic [ELEM_BITS-1:0] p
);

   localparam int unsigned HALF = ELEM_BITS / 2;
   localparam int unsigned QTR  = ELEM_BITS / 4;

   logic [ELEM_BITS-1:0] p_half;
   logic [HALF-1:0]      p_lo;
   logic [HALF-1:0]      p_hi;

   always_comb begin
      p_half = {{HALF{1'b0}}, a[HALF-1:0]} * {{HALF{1'b0}}, b[HALF-1:0]};
      p_lo   = {{QTR{1'b0}}, a[QTR-1:0]} * {{QTR{1'b0}}, b[QTR-1:0]};
      p_hi   = {{QTR{1'b0}}, a[HALF +: QTR]} * {{QTR{1'b0}}, b[HALF +: QTR]};
      p      = byte_mode ? {p_hi, p_lo} : p_half;
   end

endmodule

// File: rtl/vec_simd_alu.sv
module vec_simd_alu
   import vsa_pkg::*;
#(
   parameter int unsigned NUM_ELEM = 8,
   parameter int unsigned ELEM_W   = 32,
   parameter bit          HAS_MUL  = 1'b1,
   parameter int unsigned CARRY_SEG = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [2:0]                   op_code,
   input  logic [1:0]                   width_code,
   input  logic [NUM_ELEM*ELEM_W-1:0]   src_a,
   input  logic [NUM_ELEM*ELEM_W-1:0]   src_b,
   output logic [NUM_ELEM*ELEM_W-1:0]   result,
   output logic                         valid,
   output logic                         err
);

   localparam int unsigned VEC_W  = NUM_ELEM * ELEM_W;
   localparam int unsigned NPAIR  = NUM_ELEM / 2;

   initial begin
      if (ELEM_W != ELEM_BITS)
         $error("vec_simd_alu: element width must be %0d", ELEM_BITS);
      if (NUM_ELEM < 2 || (NUM_ELEM % 2) != 0)
         $error("vec_simd_alu: element count must be even and at least 2");
   end

   vop_e    op;
   lane_w_e wsel;
   assign op   = vop_e'(op_code);
   assign wsel = lane_w_e'(width_code);

   logic [VEC_W-1:0] arith_v;
   logic [VEC_W-1:0] shift_v;
   logic [VEC_W-1:0] mul_v;
   logic             mul_ok;

   // ---------------- per-pair add/sub and shift ----------------
   for (genvar gp = 0; gp < NPAIR; gp++) begin : g_pair
      vsa_pair_addsub #(.SEG_W(CARRY_SEG)) u_addsub (
         .a      (src_a[gp*PAIR_BITS +: PAIR_BITS]),
         .b      (src_b[gp*PAIR_BITS +: PAIR_BITS]),
         .wsel   (wsel),
         .do_sub (op == VOP_SUB),
         .sum    (arith_v[gp*PAIR_BITS +: PAIR_BITS])
      );
      vsa_pair_shift u_shift (
         .a        (src_a[gp*PAIR_BITS +: PAIR_BITS]),
         .wsel     (wsel),
         .to_right (op == VOP_SHR),
         .q        (shift_v[gp*PAIR_BITS +: PAIR_BITS])
      );
   end

   // ---------------- multiplier variant ----------------
   if (HAS_MUL) begin : g_mul
      for (genvar ge = 0; ge < NUM_ELEM; ge++) begin : g_elem
         vsa_elem_mul u_mul (
            .a         (src_a[ge*ELEM_BITS +: ELEM_BITS]),
            .b         (src_b[ge*ELEM_BITS +: ELEM_BITS]),
            .byte_mode (wsel == LW_8),
            .p         (mul_v[ge*ELEM_BITS +: ELEM_BITS])
         );
      end
      assign mul_ok = (wsel == LW_8) || (wsel == LW_16);
   end else begin : g_no_mul
      assign mul_v  = '0;
      assign mul_ok = 1'b0;
   end

   // ---------------- result select ----------------
   logic [VEC_W-1:0] next_v;
   logic             reject;

   always_comb begin
      reject = 1'b0;
      unique case (op)
         VOP_AND:          next_v = src_a & src_b;
         VOP_OR:           next_v = src_a | src_b;
         VOP_XOR:          next_v = src_a ^ src_b;
         VOP_ADD, VOP_SUB: next_v = arith_v;
         VOP_SHL, VOP_SHR: next_v = shift_v;
         VOP_MUL: begin
            next_v = mul_v;
            reject = !mul_ok;
         end
         default:          next_v = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result <= '0;
         valid  <= 1'b0;
         err    <= 1'b0;
      end else begin
         valid <= start;
         err   <= start && reject;
         if (start && !reject)
            result <= next_v;
      end
   end

   // ---------------- assertions ----------------
   a_r2_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start) |-> valid);

   a_r2_valid_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start) |-> !valid);

   a_r2_hold_without_start: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> $stable(result));

   a_r11_err_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (valid && $stable(result)));

   a_r11_err_only_mul: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && $past(op_code) != 3'd7) |-> !err);

   a_r3_xor_bitwise: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && $past(op_code) == 3'd2) |-> (result == $past(src_a ^ src_b)));

   a_r5_qw_add_pair0: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && $past(op_code) == 3'd3 && $past(width_code) == 2'd3)
      |-> (result[63:0] == $past(src_a[63:0] + src_b[63:0])));

   a_r6_qw_sub_pair0: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && $past(op_code) == 3'd4 && $past(width_code) == 2'd3)
      |-> (result[63:0] == $past(src_a[63:0] - src_b[63:0])));

endmodule

// File: tb/vec_simd_alu_bench.sv
`timescale 1ns/1ps
module vec_simd_alu_bench;

   localparam int unsigned NE = 8;
   localparam int unsigned VW = NE * 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    op_code = '0;
   logic [1:0]    width_code = '0;
   logic [VW-1:0] src_a = '0;
   logic [VW-1:0] src_b = '0;
   logic [VW-1:0] result;
   logic          valid;
   logic          err;

   int n_tests = 0;
   int n_fail  = 0;
   logic [VW-1:0] exp_res = '0;

   always #2.5 clk = ~clk;

   vec_simd_alu #(.NUM_ELEM(NE)) u_vec_simd_alu (
      .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
      .width_code(width_code), .src_a(src_a), .src_b(src_b),
      .result(result), .valid(valid), .err(err)
   );

   function automatic string req_of(input logic [2:0] op, input logic [1:0] wd);
      case (op)
         3'd0, 3'd1, 3'd2: return "R3";
         3'd3: return (wd == 2'd3) ? "R5" : "R4";
         3'd4: return "R6";
         3'd5: return "R7";
         3'd6: return "R8";
         default: return (wd[1]) ? "R11" : ((wd == 2'd1) ? "R9" : "R10");
      endcase
   endfunction

   function automatic logic [VW-1:0] model(input logic [2:0] op, input logic [1:0] wd,
                                           input logic [VW-1:0] a, input logic [VW-1:0] b,
                                           input logic [VW-1:0] prev);
      logic [VW-1:0] r;
      r = '0;
      case (op)
         3'd0: r = a & b;
         3'd1: r = a | b;
         3'd2: r = a ^ b;
         3'd7: begin
            if (wd[1]) r = prev;
            else begin
               for (int e = 0; e < NE; e++) begin
                  logic [31:0] x, y;
                  x = a[e*32 +: 32];
                  y = b[e*32 +: 32];
                  if (wd == 2'd1)
                     r[e*32 +: 32] = {16'd0, x[15:0]} * {16'd0, y[15:0]};
                  else
                     r[e*32 +: 32] = {16'({8'd0, x[23:16]} * {8'd0, y[23:16]}),
                                      16'({8'd0, x[7:0]} * {8'd0, y[7:0]})};
               end
            end
         end
         default: begin
            for (int p = 0; p < NE/2; p++) begin
               logic [63:0] x, y, acc, mask;
               int lb;
               x = a[p*64 +: 64];
               y = b[p*64 +: 64];
               lb = 8 << wd;
               mask = (lb == 64) ? {64{1'b1}} : ((64'd1 << lb) - 64'd1);
               acc = '0;
               for (int off = 0; off < 64; off += lb) begin
                  logic [63:0] xa, ya, rr;
                  xa = (x >> off) & mask;
                  ya = (y >> off) & mask;
                  case (op)
                     3'd3: rr = (xa + ya) & mask;
                     3'd4: rr = (xa - ya) & mask;
                     3'd5: rr = (xa << 1) & mask;
                     default: rr = xa >> 1;
                  endcase
                  acc = acc | (rr << off);
               end
               r[p*64 +: 64] = acc;
            end
         end
      endcase
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [VW-1:0] act, input logic [VW-1:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   task automatic run_op(input logic [2:0] op, input logic [1:0] wd,
                         input logic [VW-1:0] a, input logic [VW-1:0] b);
      logic bad;
      string rq;
      bad = (op == 3'd7) && wd[1];
      rq  = req_of(op, wd);
      exp_res = model(op, wd, a, b, exp_res);
      @(negedge clk);
      op_code = op; width_code = wd; src_a = a; src_b = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      src_a = ~a; src_b = ~b;
      check(valid === 1'b1, "R2", "valid after start", VW'(valid), VW'(1));
      check(err === bad, "R11", "err flag", VW'(err), VW'(bad));
      check(result === exp_res, rq, "result", result, exp_res);
   endtask

   logic [VW-1:0] ra, rb;

   function automatic logic [VW-1:0] rnd_vec();
      logic [VW-1:0] v;
      for (int e = 0; e < NE; e++) v[e*32 +: 32] = $urandom;
      return v;
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(valid === 1'b0 && err === 1'b0, "R1", "flags in reset", VW'({valid, err}), '0);
      check(result === '0, "R1", "result in reset", result, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(valid === 1'b0 && result === '0, "R1", "idle after reset", result, '0);

      // R3: logic ignores the width code
      ra = rnd_vec(); rb = rnd_vec();
      run_op(3'd0, 2'd3, ra, rb);
      run_op(3'd1, 2'd0, ra, rb);
      run_op(3'd2, 2'd2, ra, rb);
      // R2: single pulse, result held while idle
      @(negedge clk);
      check(valid === 1'b0, "R2", "valid drops", VW'(valid), '0);
      check(result === exp_res, "R2", "result held", result, exp_res);

      // R5: carry crosses from element 0 into element 1
      ra = '0; rb = '0; ra[31:0] = 32'hFFFF_FFFF; rb[31:0] = 32'h1;
      run_op(3'd3, 2'd3, ra, rb);
      check(result[63:32] === 32'h1, "R5", "carry into high element", VW'(result[63:32]), VW'(1));
      // R4: same operands, 32-bit lanes, no carry out
      run_op(3'd3, 2'd2, ra, rb);
      // R4: byte lane wrap stays local
      ra = '0; rb = '0; ra[7:0] = 8'hFF; rb[7:0] = 8'h01;
      run_op(3'd3, 2'd0, ra, rb);
      run_op(3'd3, 2'd1, ra, rb);
      // R6: borrow through the pair
      ra = '0; rb = '0; rb[31:0] = 32'h1;
      run_op(3'd4, 2'd3, ra, rb);
      run_op(3'd4, 2'd0, ra, rb);
      // R7: bit 31 into high element
      ra = '0; ra[31:0] = 32'h8000_0000; ra[159:128] = 32'h8000_8080;
      run_op(3'd5, 2'd3, ra, '0);
      run_op(3'd5, 2'd2, ra, '0);
      run_op(3'd5, 2'd0, ra, '0);
      // R8: high bit 0 into low bit 31
      ra = '0; ra[32] = 1'b1; ra[96] = 1'b1; ra[8] = 1'b1;
      run_op(3'd6, 2'd3, ra, '0);
      run_op(3'd6, 2'd1, ra, '0);
      // R9 / R10: extreme multiplier operands
      ra = {NE{32'hFFFF_FFFF}};
      run_op(3'd7, 2'd1, ra, ra);
      run_op(3'd7, 2'd0, ra, ra);
      // R11: rejected widths keep result
      run_op(3'd7, 2'd2, rnd_vec(), rnd_vec());
      run_op(3'd7, 2'd3, rnd_vec(), rnd_vec());

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [2:0] o;
         logic [1:0] w;
         o = 3'($urandom_range(0, 7));
         w = 2'($urandom_range(0, 3));
         run_op(o, w, rnd_vec(), rnd_vec());
         if (($urandom & 3) == 0) @(negedge clk);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule